// File: doc/BRIEF.md
# Transmit Frame Length Processor

This block takes page numbers from a small transmit queue and turns each referenced page of packet memory into an outgoing byte stream. For every page it reads a little-endian byte count and a trailing control byte, stamps a fixed two-byte status word over the start of the page, and works out how many bytes leave the block. A control flag can add one odd trailing byte, and short frames can be zero-filled up to a minimum size. The frame is then sent on a byte-wide valid/ready stream with first and last markers and a length sideband.

After each frame the page is either handed straight back through a one-cycle release pulse or appended to a completion queue that the host drains. The engine starts only while transmit is enabled. It empties the queue in push order and removes each entry once its frame has gone out. Packet memory lives outside the block and is reached through a synchronous read port with one cycle of latency and a separate write port.

Top module: `txlen_engine`

## Requirements
- R1: For each frame the block writes 0x01 to page offset 0 and 0x40 to page offset 1, and writes no other memory location. Padding is never written to memory.
- R2: The payload length is the 16-bit count at offsets 2 (low byte) and 3 (high byte) minus 6. Payload bytes are sent from offset 4 upward in order, and a length of zero sends no bytes.
- R3: The control byte sits at page offset count-1. If its bit 5 is set, one more payload byte (the one at offset 4+length) is sent.
- R4: With padding enabled and a length below 64, zero bytes are appended up to 64. With padding disabled, or with a length of 64 or more, no bytes are appended.
- R5: No frame is started while transmit enable is low. Queued pages wait until it goes high.
- R6: The transmit queue holds up to 4 pages. A push while it is full is ignored. Queued frames go out in push order and each entry is removed once its frame is done.
- R7: The first byte of a frame carries out_first and the final byte carries out_last. out_len equals the number of bytes in the frame.
- R8: While out_valid is high and out_ready is low, out_data and the markers stay unchanged, and no byte is lost or repeated.
- R9: With auto-release set, each finished frame gives a one-cycle rel_valid with its page on rel_page and adds no completion entry.
- R10: Without auto-release, each finished page is appended to the completion queue in order. The queue holds 4 entries, and a completion that arrives while it is full is dropped. done_pop removes the head.
- R11: After reset no stream byte, memory access, release or completion is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_pad_en | input | 1 | Zero-fill short frames to the minimum size |
| cfg_auto_release | input | 1 | Release pages instead of queueing completions |
| q_push | input | 1 | Push a page number onto the transmit queue |
| q_page | input | PAGE_W | Page number to push |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Read address {page, offset} |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Write address {page, offset} |
| mem_wr_data | output | 8 | Write data |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_first | output | 1 | First byte of frame |
| out_last | output | 1 | Last byte of frame |
| out_len | output | 16 | Length of the current frame |
| rel_valid | output | 1 | Page release pulse |
| rel_page | output | PAGE_W | Released page |
| done_valid | output | 1 | Completion queue not empty |
| done_page | output | PAGE_W | Head of the completion queue |
| done_pop | input | 1 | Remove the completion queue head |

## Verification
Frames with even and odd counts tell a correct control-byte address and flag test apart from an off-by-one. Short frames sent with padding on and off, plus a frame longer than the minimum, separate the pad decision from the length arithmetic. A zero-length frame checks the empty-payload path. Pages queued while transmit is disabled, with one push too many, check gating, queue capacity and ordering. A pseudo-random ready pattern over padded and odd frames shows whether a stall can drop or change a byte.

// File: rtl/txlen_pkg.sv
package txlen_pkg;
   localparam int CNT_W = 16;
   localparam logic [CNT_W-1:0] CNT_OVERHEAD = 16'd6;
   localparam logic [CNT_W-1:0] OFS_CNT_LO   = 16'd2;
   localparam logic [CNT_W-1:0] OFS_CNT_HI   = 16'd3;
   localparam logic [CNT_W-1:0] OFS_PAYLOAD  = 16'd4;
   localparam int ODD_FLAG_BIT = 5;
   localparam logic [7:0] STATUS_B0 = 8'h01;
   localparam logic [7:0] STATUS_B1 = 8'h40;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CNT_HI,
      ST_CTL_ADDR,
      ST_CTL_WAIT,
      ST_STREAM,
      ST_FINISH
   } walk_state_t;
endpackage

// File: rtl/txlen_page_fifo.sv
module txlen_page_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic [W-1:0]  slot [DEPTH];
   logic          push_ok, pop_ok;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = slot[rd_ptr];

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_ok && wr_ptr == AW'(g)) slot[g] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push_ok) wr_ptr <= bump(wr_ptr);
         if (pop_ok)  rd_ptr <= bump(rd_ptr);
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/txlen_walker.sv
module txlen_walker
   import txlen_pkg::*;
#(
   parameter int PAGE_W    = 2,
   parameter int OFF_W     = 11,
   parameter int MIN_FRAME = 64,
   parameter bit PAD_IMPL  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_tx_en,
   input  logic                    cfg_pad_en,
   input  logic                    q_empty,
   input  logic [PAGE_W-1:0]       q_head,
   output logic                    q_pop,
   output logic                    mem_rd_en,
   output logic [PAGE_W+OFF_W-1:0] mem_rd_addr,
   input  logic [7:0]              mem_rd_data,
   output logic                    mem_wr_en,
   output logic [PAGE_W+OFF_W-1:0] mem_wr_addr,
   output logic [7:0]              mem_wr_data,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [7:0]              out_data,
   output logic                    out_first,
   output logic                    out_last,
   output logic [CNT_W-1:0]        out_len,
   output logic                    fin_valid,
   output logic [PAGE_W-1:0]       fin_page
);
   localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(MIN_FRAME);

   walk_state_t       state_q;
   logic [PAGE_W-1:0] page_q;
   logic [7:0]        cnt_lo_q, hold_q;
   logic [CNT_W-1:0]  base_len_q, data_len_q, frame_len_q, idx_q;
   logic              fresh_q;

   logic [CNT_W-1:0]  count_c, data_len_c, frame_len_c, idx_next;
   logic              odd_c, is_pad_c, last_c, go_c;
   logic [7:0]        cur_byte;
   logic [PAGE_W-1:0] rd_pg;
   logic [OFF_W-1:0]  rd_off, wr_off;

   assign count_c    = {mem_rd_data, cnt_lo_q};
   assign odd_c      = mem_rd_data[ODD_FLAG_BIT];
   assign data_len_c = base_len_q + CNT_W'(odd_c);
   assign idx_next   = idx_q + 1'b1;
   assign is_pad_c   = (idx_q >= data_len_q);
   assign last_c     = (idx_q == frame_len_q - 1'b1);
   assign go_c       = cfg_tx_en && !q_empty;
   assign cur_byte   = is_pad_c ? 8'h00 : (fresh_q ? mem_rd_data : hold_q);

   if (PAD_IMPL) begin : g_pad
      assign frame_len_c = (cfg_pad_en && data_len_c < MIN_LEN) ? MIN_LEN : data_len_c;
   end else begin : g_nopad
      assign frame_len_c = data_len_c;
   end

   always_comb begin
      mem_rd_en   = 1'b0;
      rd_pg       = page_q;
      rd_off      = '0;
      mem_wr_en   = 1'b0;
      wr_off      = '0;
      mem_wr_data = 8'h00;
      q_pop       = 1'b0;
      fin_valid   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (go_c) begin
               mem_rd_en = 1'b1;
               rd_pg     = q_head;
               rd_off    = OFF_W'(OFS_CNT_LO);
            end
         end
         ST_CNT_HI: begin
            mem_rd_en   = 1'b1;
            rd_off      = OFF_W'(OFS_CNT_HI);
            mem_wr_en   = 1'b1;
            wr_off      = '0;
            mem_wr_data = STATUS_B0;
         end
         ST_CTL_ADDR: begin
            mem_rd_en   = 1'b1;
            rd_off      = OFF_W'(count_c - 1'b1);
            mem_wr_en   = 1'b1;
            wr_off      = OFF_W'(1);
            mem_wr_data = STATUS_B1;
         end
         ST_CTL_WAIT: begin
            mem_rd_en = (data_len_c != '0);
            rd_off    = OFF_W'(OFS_PAYLOAD);
         end
         ST_STREAM: begin
            mem_rd_en = out_ready && !last_c && (idx_next < data_len_q);
            rd_off    = OFF_W'(OFS_PAYLOAD + idx_next);
         end
         ST_FINISH: begin
            q_pop     = 1'b1;
            fin_valid = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_rd_addr = {rd_pg, rd_off};
   assign mem_wr_addr = {page_q, wr_off};
   assign out_valid   = (state_q == ST_STREAM);
   assign out_data    = cur_byte;
   assign out_first   = out_valid && (idx_q == '0);
   assign out_last    = out_valid && last_c;
   assign out_len     = frame_len_q;
   assign fin_page    = page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         page_q      <= '0;
         cnt_lo_q    <= '0;
         hold_q      <= '0;
         base_len_q  <= '0;
         data_len_q  <= '0;
         frame_len_q <= '0;
         idx_q       <= '0;
         fresh_q     <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go_c) begin
                  page_q  <= q_head;
                  state_q <= ST_CNT_HI;
               end
            end
            ST_CNT_HI: begin
               cnt_lo_q <= mem_rd_data;
               state_q  <= ST_CTL_ADDR;
            end
            ST_CTL_ADDR: begin
               base_len_q <= count_c - CNT_OVERHEAD;
               state_q    <= ST_CTL_WAIT;
            end
            ST_CTL_WAIT: begin
               data_len_q  <= data_len_c;
               frame_len_q <= frame_len_c;
               idx_q       <= '0;
               fresh_q     <= 1'b1;
               state_q     <= (frame_len_c == '0) ? ST_FINISH : ST_STREAM;
            end
            ST_STREAM: begin
               if (out_ready) begin
                  if (last_c) begin
                     state_q <= ST_FINISH;
                  end else begin
                     idx_q   <= idx_next;
                     fresh_q <= 1'b1;
                  end
               end else begin
                  hold_q  <= cur_byte;
                  fresh_q <= 1'b0;
               end
            end
            ST_FINISH: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/txlen_engine.sv
module txlen_engine
   import txlen_pkg::*;
#(
   parameter int NUM_PAGES  = 4,
   parameter int PAGE_BYTES = 2048,
   parameter int MIN_FRAME  = 64,
   parameter bit PAD_IMPL   = 1'b1,
   parameter int DONE_DEPTH = NUM_PAGES,
   localparam int PAGE_W    = $clog2(NUM_PAGES),
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int ADDR_W    = PAGE_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_tx_en,
   input  logic              cfg_pad_en,
   input  logic              cfg_auto_release,
   input  logic              q_push,
   input  logic [PAGE_W-1:0] q_page,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [7:0]        mem_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [7:0]        mem_wr_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [7:0]        out_data,
   output logic              out_first,
   output logic              out_last,
   output logic [15:0]       out_len,
   output logic              rel_valid,
   output logic [PAGE_W-1:0] rel_page,
   output logic              done_valid,
   output logic [PAGE_W-1:0] done_page,
   input  logic              done_pop
);
   if (NUM_PAGES < 2 || (1 << PAGE_W) != NUM_PAGES) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two of at least 2");
   end
   if ((1 << OFF_W) != PAGE_BYTES || OFF_W > CNT_W || PAGE_BYTES < 8) begin : g_bad_page_size
      $error("PAGE_BYTES must be a power of two between 8 and 65536");
   end
   if (MIN_FRAME < 1 || MIN_FRAME > PAGE_BYTES) begin : g_bad_min
      $error("MIN_FRAME out of range");
   end
   if (DONE_DEPTH < 2) begin : g_bad_done
      $error("DONE_DEPTH must be at least 2");
   end

   logic              txq_empty, txq_full, txq_pop;
   logic [PAGE_W-1:0] txq_head;
   logic              fin_valid, done_empty, done_full;
   logic [PAGE_W-1:0] fin_page;

   txlen_page_fifo #(.DEPTH(NUM_PAGES), .W(PAGE_W)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .push_data(q_page),
      .pop(txq_pop), .head(txq_head),
      .empty(txq_empty), .full(txq_full)
   );

   txlen_walker #(
      .PAGE_W(PAGE_W), .OFF_W(OFF_W), .MIN_FRAME(MIN_FRAME), .PAD_IMPL(PAD_IMPL)
   ) u_walk (
      .clk(clk), .rst_n(rst_n),
      .cfg_tx_en(cfg_tx_en), .cfg_pad_en(cfg_pad_en),
      .q_empty(txq_empty), .q_head(txq_head), .q_pop(txq_pop),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_first(out_first), .out_last(out_last), .out_len(out_len),
      .fin_valid(fin_valid), .fin_page(fin_page)
   );

   txlen_page_fifo #(.DEPTH(DONE_DEPTH), .W(PAGE_W)) u_doneq (
      .clk(clk), .rst_n(rst_n),
      .push(fin_valid && !cfg_auto_release), .push_data(fin_page),
      .pop(done_pop), .head(done_page),
      .empty(done_empty), .full(done_full)
   );

   assign rel_valid  = fin_valid && cfg_auto_release;
   assign rel_page   = fin_page;
   assign done_valid = !done_empty;
endmodule

// File: rtl/txlen_checker.sv
module txlen_checker #(
   parameter int OFF_W  = 11,
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_tx_en,
   input logic              mem_rd_en,
   input logic              mem_wr_en,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [7:0]        mem_wr_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [7:0]        out_data,
   input logic              out_first,
   input logic              out_last,
   input logic              rel_valid,
   input logic              done_valid,
   input logic              done_pop
);
   assert_status_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> ((mem_wr_addr[OFF_W-1:0] == '0 && mem_wr_data == 8'h01) ||
                     (mem_wr_addr[OFF_W-1:0] == OFF_W'(1) && mem_wr_data == 8'h40)));

   assert_no_write_in_stream_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !mem_wr_en);

   assert_quiet_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_tx_en && !out_valid && !mem_rd_en && !mem_wr_en) |=> (cfg_tx_en || !mem_rd_en));

   assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                     $stable(out_first) && $stable(out_last)));

   assert_release_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |=> !rel_valid);

   assert_done_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_pop) |=> done_valid);
endmodule

bind txlen_engine txlen_checker #(.OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en),
   .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
   .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .out_first(out_first), .out_last(out_last),
   .rel_valid(rel_valid), .done_valid(done_valid), .done_pop(done_pop)
);

// File: tb/sim_txlen_engine.sv
module sim_txlen_engine;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int PB = 256;
   localparam int AW = 10;
   localparam int CAP = 2048;

   logic clk = 1'b0;
   logic rst_n;
   logic cfg_tx_en, cfg_pad_en, cfg_auto_release;
   logic q_push;
   logic [1:0] q_page;
   logic mem_rd_en, mem_wr_en;
   logic [AW-1:0] mem_rd_addr, mem_wr_addr;
   logic [7:0] mem_rd_data, mem_wr_data;
   logic out_valid, out_ready, out_first, out_last;
   logic [7:0] out_data;
   logic [15:0] out_len;
   logic rel_valid, done_valid, done_pop;
   logic [1:0] rel_page, done_page;

   always #(CLK_PERIOD/2) clk = ~clk;

   txlen_engine #(.NUM_PAGES(NP), .PAGE_BYTES(PB)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_tx_en(cfg_tx_en), .cfg_pad_en(cfg_pad_en), .cfg_auto_release(cfg_auto_release),
      .q_push(q_push), .q_page(q_page),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_first(out_first), .out_last(out_last), .out_len(out_len),
      .rel_valid(rel_valid), .rel_page(rel_page),
      .done_valid(done_valid), .done_page(done_page), .done_pop(done_pop)
   );

   logic [7:0] mem [0:NP*PB-1];
   int stray_writes = 0;

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
      if (mem_wr_en) begin
         mem[mem_wr_addr] <= mem_wr_data;
         if (mem_wr_addr[7:0] > 8'd1) stray_writes++;
      end
   end

   int checks = 0, failures = 0;
   bit ended = 0;
   logic [26:0] cap [0:CAP-1];
   logic [26:0] expv [0:CAP-1];
   int cap_n = 0, exp_n = 0;
   logic [1:0] rel_log [0:63];
   int rel_n = 0;
   bit stall_mode = 0;
   logic [7:0] lf = 8'hA5;
   bit prev_stall = 0;
   logic [9:0] prev_sig;
   int stall_err = 0;

   always @(negedge clk) begin
      if (prev_stall && out_valid && prev_sig != {out_data, out_first, out_last}) stall_err++;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = stall_mode ? (lf[1:0] != 2'b00) : 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_sig = {out_data, out_first, out_last};
      if (out_valid && out_ready && cap_n < CAP) begin
         cap[cap_n] = {out_data, out_first, out_last, out_len, 1'b0};
         cap_n++;
      end
      if (rel_valid && rel_n < 64) begin
         rel_log[rel_n] = rel_page;
         rel_n++;
      end
   end

   task automatic report();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expd);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expd);
      end
   endtask

   function automatic logic [7:0] pay(input int p, input int i);
      return 8'(p * 37 + i * 3 + 1);
   endfunction

   task automatic set_page(input int p, input int base, input bit odd);
      int count = base + 6;
      mem[p*PB+0] = 8'hEE;
      mem[p*PB+1] = 8'hEE;
      mem[p*PB+2] = 8'(count);
      mem[p*PB+3] = 8'(count >> 8);
      for (int i = 0; i < PB - 4; i++) mem[p*PB+4+i] = pay(p, i);
      mem[p*PB + ((count - 1) % PB)] = odd ? 8'h2A : 8'h0A;
   endtask

   task automatic add_exp(input int p, input int base, input bit odd, input bit pad);
      int dl = base + int'(odd);
      int fl = (pad && dl < 64) ? 64 : dl;
      for (int i = 0; i < fl; i++) begin
         expv[exp_n] = {(i < dl) ? pay(p, i) : 8'h00, i == 0, i == fl - 1, 16'(fl), 1'b0};
         exp_n++;
      end
   endtask

   task automatic push(input int p);
      q_push = 1'b1;
      q_page = 2'(p);
      @(negedge clk);
      q_push = 1'b0;
   endtask

   task automatic wait_out();
      while (cap_n < exp_n) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic cmp_stream(input int from, input string req);
      int bad = -1;
      chk(cap_n == exp_n, req, "byte count", cap_n - from, exp_n - from);
      for (int i = from; i < exp_n && i < cap_n; i++)
         if (bad < 0 && cap[i] != expv[i]) bad = i;
      checks++;
      if (bad >= 0) begin
         failures++;
         $display("FAIL %s stream byte %0d: actual=%h expected=%h", req, bad - from, cap[bad], expv[bad]);
      end
      cap_n = exp_n;
   endtask

   task automatic pop_done(input int p, input string req);
      chk(done_valid == 1'b1, req, "done_valid", int'(done_valid), 1);
      chk(done_page == 2'(p), req, "done_page", int'(done_page), p);
      done_pop = 1'b1;
      @(negedge clk);
      done_pop = 1'b0;
   endtask

   task automatic t_reset();
      chk(!out_valid && !mem_rd_en && !mem_wr_en, "R11", "idle outputs",
          int'({out_valid, mem_rd_en, mem_wr_en}), 0);
      chk(!rel_valid && !done_valid, "R11", "no release/done", int'({rel_valid, done_valid}), 0);
   endtask

   task automatic t_basic();
      int s = exp_n;
      cfg_tx_en = 1; cfg_pad_en = 0; cfg_auto_release = 0;
      set_page(0, 20, 0);
      add_exp(0, 20, 0, 0);
      push(0);
      wait_out();
      cmp_stream(s, "R2 R7");
      chk(mem[0] == 8'h01 && mem[1] == 8'h40, "R1", "status word", int'({mem[0], mem[1]}), 'h0140);
      pop_done(0, "R10");
   endtask

   task automatic t_odd();
      int s = exp_n;
      set_page(1, 21, 1);
      set_page(2, 21, 0);
      add_exp(1, 21, 1, 0);
      add_exp(2, 21, 0, 0);
      push(1);
      push(2);
      wait_out();
      cmp_stream(s, "R3");
      pop_done(1, "R10");
      pop_done(2, "R10");
   endtask

   task automatic t_pad();
      int s = exp_n;
      cfg_pad_en = 1;
      set_page(3, 10, 0);
      set_page(0, 9, 1);
      set_page(1, 70, 0);
      add_exp(3, 10, 0, 1);
      add_exp(0, 9, 1, 1);
      add_exp(1, 70, 0, 1);
      push(3); push(0); push(1);
      wait_out();
      cmp_stream(s, "R4");
      chk(mem[3*PB+4+10] == pay(3, 10), "R1", "pad not in memory", int'(mem[3*PB+14]), int'(pay(3, 10)));
      pop_done(3, "R10"); pop_done(0, "R10"); pop_done(1, "R10");
      cfg_pad_en = 0;
   endtask

   task automatic t_gate();
      int s = exp_n;
      cfg_tx_en = 0;
      set_page(2, 12, 0); set_page(0, 13, 1); set_page(3, 14, 0); set_page(1, 15, 1);
      push(2); push(0); push(3); push(1); push(2);
      repeat (40) @(negedge clk);
      chk(cap_n == s, "R5", "bytes while disabled", cap_n - s, 0);
      chk(!done_valid, "R5", "no completion while disabled", int'(done_valid), 0);
      add_exp(2, 12, 0, 0); add_exp(0, 13, 1, 0); add_exp(3, 14, 0, 0); add_exp(1, 15, 1, 0);
      cfg_tx_en = 1;
      wait_out();
      cmp_stream(s, "R6");
      pop_done(2, "R6"); pop_done(0, "R6"); pop_done(3, "R6"); pop_done(1, "R6");
      chk(!done_valid, "R6", "fifth push ignored", int'(done_valid), 0);
   endtask

   task automatic t_done_full();
      int s = exp_n;
      for (int p = 0; p < 4; p++) begin
         set_page(p, 8 + p, 0);
         add_exp(p, 8 + p, 0, 0);
         push(p);
      end
      wait_out();
      add_exp(0, 8, 0, 0);
      push(0);
      wait_out();
      cmp_stream(s, "R10");
      for (int p = 0; p < 4; p++) pop_done(p, "R10");
      chk(!done_valid, "R10", "overflow completion dropped", int'(done_valid), 0);
   endtask

   task automatic t_zero();
      set_page(2, 0, 0);
      push(2);
      repeat (20) @(negedge clk);
      chk(cap_n == exp_n, "R2", "zero length sends nothing", cap_n, exp_n);
      pop_done(2, "R2");
   endtask

   task automatic t_release();
      int s = exp_n;
      int r0 = rel_n;
      cfg_auto_release = 1;
      set_page(3, 16, 0); set_page(1, 17, 1);
      add_exp(3, 16, 0, 0); add_exp(1, 17, 1, 0);
      push(3); push(1);
      wait_out();
      cmp_stream(s, "R9");
      chk(rel_n - r0 == 2, "R9", "release count", rel_n - r0, 2);
      chk(rel_log[r0] == 2'd3 && rel_log[r0+1] == 2'd1, "R9", "release order",
          int'({rel_log[r0], rel_log[r0+1]}), 'hD);
      chk(!done_valid, "R9", "no completion entry", int'(done_valid), 0);
   endtask

   task automatic t_stall();
      int s = exp_n;
      stall_mode = 1; cfg_pad_en = 1;
      set_page(0, 5, 0); set_page(1, 40, 1); set_page(2, 90, 1);
      add_exp(0, 5, 0, 1); add_exp(1, 40, 1, 1); add_exp(2, 90, 1, 1);
      push(0); push(1); push(2);
      wait_out();
      cmp_stream(s, "R8");
      chk(stall_err == 0, "R8", "output changed while stalled", stall_err, 0);
      stall_mode = 0; cfg_pad_en = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL R6 watchdog: actual=hung expected=complete");
      report();
   end

   initial begin
      rst_n = 0; q_push = 0; q_page = 0; done_pop = 0;
      cfg_tx_en = 0; cfg_pad_en = 0; cfg_auto_release = 0;
      for (int i = 0; i < NP*PB; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_odd();
      t_pad();
      t_gate();
      t_done_full();
      t_zero();
      t_release();
      t_stall();
      chk(stray_writes == 0, "R1", "writes outside status word", stray_writes, 0);
      report();
   end
endmodule